// File: doc/BRIEF.md
# Multi-Window Memory Target Decoder

This block sits behind a bus target front end and steers each memory-space request into one of three address windows, each with a programmable base. The first window reaches a control-register file. The second and third windows reach the same dual-processor memory. One presents that memory as 24-bit words and the other as 16-bit words. Each memory window is split in half. The lower half goes to processor 0 and the upper half to processor 1.

A request is a single-cycle pulse on `req_valid` that carries an address, byte enables, a direction and write data. The requester presents no new request until the previous one has completed. A register request produces a one-cycle strobe on the register bus. A memory request produces a held request that carries the processor select, the word width and a word offset; it stays up until the memory acknowledges, so one word moves per request. A request the block cannot serve completes with an error flag and all-ones read data. A request that hits no window, or arrives while memory space is disabled, is dropped without any response.

Top module: `mem_window_decoder`

## Requirements
- R1: A request in the register window with all four byte enables set raises `reg_strobe` for exactly one cycle, starting one cycle after the request. The strobe carries `reg_addr` = address minus register base, plus the byte enables, direction and write data. `resp_valid` follows one cycle later; its `resp_rdata` is the sampled `reg_rdata` on a read and zero on a write.
- R2: A register request with partial byte enables (anything other than 4'hF) is accepted only when its offset is below 2**LOCAL_REG_LG (the interface-local registers). At or above that offset it is rejected.
- R3: A request in the 24-bit window with full byte enables raises `mem_req` with `mem_wide`=1 and `mem_wdata` = `req_wdata[23:0]`. A read completes with `mem_rdata` zero-extended to 32 bits.
- R4: A request in the 16-bit window raises `mem_req` with `mem_wide`=0 and `mem_wdata` = {8'h00, `req_wdata[15:0]`}. A read completes with `mem_rdata[15:0]` zero-extended to 32 bits.
- R5: Within either memory window, `mem_dsp_sel` is 0 for offsets in the lower half and 1 for the upper half. `mem_word_off` = (offset modulo half the window size) / 4.
- R6: A memory-window request whose byte enables are not 4'hF is rejected and raises no `mem_req`.
- R7: While `mem_space_en` is 0, no request in any window produces a strobe, a memory request or a response.
- R8: A request that falls in none of the three windows produces no strobe, no memory request and no response.
- R9: A rejected request gives `resp_valid` and `resp_err` high for one cycle, one cycle after the request, with `resp_rdata` = 32'hFFFF_FFFF. No strobe and no memory request are issued for it.
- R10: `mem_req` and its fields hold steady until `mem_ack` is sampled high. At that edge `mem_req` drops and `resp_valid` rises, so the response appears one cycle after the acknowledging edge.
- R11: When windows overlap, the register window wins over the 24-bit window, and the 24-bit window wins over the 16-bit window.
- R12: After reset, `reg_strobe`, `mem_req`, `resp_valid` and `resp_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_space_en | input | 1 | Memory-space decoding enable |
| base_regs | input | 32 | Base of the register window |
| base_w24 | input | 32 | Base of the 24-bit memory window |
| base_w16 | input | 32 | Base of the 16-bit memory window |
| req_valid | input | 1 | Request pulse |
| req_addr | input | 32 | Request byte address |
| req_be | input | 4 | Request byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Request write data |
| resp_valid | output | 1 | Completion pulse |
| resp_err | output | 1 | Completion is an error |
| resp_rdata | output | 32 | Completion read data |
| reg_strobe | output | 1 | Register-bus access strobe |
| reg_addr | output | REG_WIN_LG | Register offset |
| reg_be | output | 4 | Register byte enables |
| reg_write | output | 1 | Register direction |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, sampled the cycle after the strobe |
| mem_req | output | 1 | Memory word request, held until acknowledged |
| mem_dsp_sel | output | 1 | Processor select |
| mem_wide | output | 1 | 1 = 24-bit word, 0 = 16-bit word |
| mem_word_off | output | MEM_WIN_LG-3 | Word offset within the processor's half |
| mem_write | output | 1 | Memory direction |
| mem_wdata | output | 24 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 24 | Memory read data, valid with acknowledge |

## Verification
Strobes, memory requests and error completions are due one cycle after the request. A register completion is due two cycles after the request, and a memory completion one cycle after the edge that samples `mem_ack`. Every scenario task drives inputs on a falling edge and samples on the next falling edges, counting these registers. For dropped requests, each scenario task watches three consecutive cycles after the request for silence on every strobe and on the completion. The memory scenario tasks hold `mem_ack` low for one extra cycle to show that the request and its fields hold steady.

// File: rtl/win_pkg.sv
package win_pkg;

  localparam int TGT_AW = 32;

  typedef enum logic [1:0] {
    K_NONE,
    K_REG,
    K_MEM,
    K_ERR
  } acc_kind_e;

  // True when addr lies in the power-of-two window of size 2**lg at base.
  function automatic logic win_hit(input logic [TGT_AW-1:0] addr,
                                   input logic [TGT_AW-1:0] base,
                                   input int lg);
    logic [TGT_AW-1:0] mask;
    mask = ~((TGT_AW'(1) << lg) - TGT_AW'(1));
    return (addr & mask) == (base & mask);
  endfunction

  // Zero-extend a memory word to the response width by word width.
  function automatic logic [31:0] mem_to_resp(input logic [23:0] w,
                                              input logic wide);
    return wide ? {8'h00, w} : {16'h0000, w[15:0]};
  endfunction

  // Place request data onto the memory write lane by word width.
  function automatic logic [23:0] req_to_mem(input logic [31:0] d,
                                             input logic wide);
    return wide ? d[23:0] : {8'h00, d[15:0]};
  endfunction

endpackage

// File: rtl/win_classify.sv
module win_classify
  import win_pkg::*;
#(
  parameter int REG_WIN_LG   = 12,
  parameter int MEM_WIN_LG   = 16,
  parameter int LOCAL_REG_LG = 8,
  localparam int WORD_W      = MEM_WIN_LG - 3
) (
  input  logic                  en,
  input  logic [TGT_AW-1:0]     base_regs,
  input  logic [TGT_AW-1:0]     base_w24,
  input  logic [TGT_AW-1:0]     base_w16,
  input  logic [TGT_AW-1:0]     addr,
  input  logic [3:0]            be,
  output acc_kind_e             kind,
  output logic [REG_WIN_LG-1:0] reg_off,
  output logic                  dsp_sel,
  output logic                  wide,
  output logic [WORD_W-1:0]     word_off
);

  localparam int NWIN = 3;
  localparam int WIN_LG [NWIN] = '{REG_WIN_LG, MEM_WIN_LG, MEM_WIN_LG};

  logic [TGT_AW-1:0] bases [NWIN];
  logic [NWIN-1:0]   hit;
  logic              full_be;
  logic              local_reg;

  assign bases[0] = base_regs;
  assign bases[1] = base_w24;
  assign bases[2] = base_w16;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = win_hit(addr, bases[w], WIN_LG[w]);
  end

  assign full_be   = (be == 4'hF);
  assign reg_off   = addr[REG_WIN_LG-1:0];
  assign local_reg = (addr[REG_WIN_LG-1:LOCAL_REG_LG] == '0);
  assign dsp_sel   = addr[MEM_WIN_LG-1];
  assign word_off  = addr[MEM_WIN_LG-2:2];
  assign wide      = hit[1];

  always_comb begin
    kind = K_NONE;
    if (en) begin
      if (hit[0])
        kind = (full_be || local_reg) ? K_REG : K_ERR;
      else if (hit[1] || hit[2])
        kind = full_be ? K_MEM : K_ERR;
    end
  end

endmodule

// File: rtl/win_sequencer.sv
module win_sequencer
  import win_pkg::*;
#(
  parameter int REG_WIN_LG = 12,
  parameter int WORD_W     = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  acc_kind_e             kind,
  input  logic [REG_WIN_LG-1:0] reg_off,
  input  logic [3:0]            be,
  input  logic                  write,
  input  logic [31:0]           wdata,
  input  logic                  dsp_sel,
  input  logic                  wide,
  input  logic [WORD_W-1:0]     word_off,
  output logic                  busy,
  output logic                  resp_valid,
  output logic                  resp_err,
  output logic [31:0]           resp_rdata,
  output logic                  reg_strobe,
  output logic [REG_WIN_LG-1:0] reg_addr,
  output logic [3:0]            reg_be,
  output logic                  reg_write,
  output logic [31:0]           reg_wdata,
  input  logic [31:0]           reg_rdata,
  output logic                  mem_req,
  output logic                  mem_dsp_sel,
  output logic                  mem_wide,
  output logic [WORD_W-1:0]     mem_word_off,
  output logic                  mem_write,
  output logic [23:0]           mem_wdata,
  input  logic                  mem_ack,
  input  logic [23:0]           mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_REG, S_MEM} seq_state_e;
  seq_state_e state;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      resp_valid   <= 1'b0;
      resp_err     <= 1'b0;
      resp_rdata   <= '0;
      reg_strobe   <= 1'b0;
      reg_addr     <= '0;
      reg_be       <= '0;
      reg_write    <= 1'b0;
      reg_wdata    <= '0;
      mem_req      <= 1'b0;
      mem_dsp_sel  <= 1'b0;
      mem_wide     <= 1'b0;
      mem_word_off <= '0;
      mem_write    <= 1'b0;
      mem_wdata    <= '0;
    end else begin
      reg_strobe <= 1'b0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          unique case (kind)
            K_REG: begin
              reg_strobe <= 1'b1;
              reg_addr   <= reg_off;
              reg_be     <= be;
              reg_write  <= write;
              reg_wdata  <= wdata;
              state      <= S_REG;
            end
            K_MEM: begin
              mem_req      <= 1'b1;
              mem_dsp_sel  <= dsp_sel;
              mem_wide     <= wide;
              mem_word_off <= word_off;
              mem_write    <= write;
              mem_wdata    <= req_to_mem(wdata, wide);
              state        <= S_MEM;
            end
            K_ERR: begin
              resp_valid <= 1'b1;
              resp_err   <= 1'b1;
              resp_rdata <= '1;
            end
            default: ;
          endcase
        end
        S_REG: begin
          resp_valid <= 1'b1;
          resp_rdata <= reg_write ? 32'h0 : reg_rdata;
          state      <= S_IDLE;
        end
        S_MEM: if (mem_ack) begin
          mem_req    <= 1'b0;
          resp_valid <= 1'b1;
          resp_rdata <= mem_write ? 32'h0 : mem_to_resp(mem_rdata, mem_wide);
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  reg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_strobe |=> !reg_strobe && resp_valid && !resp_err);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_word_off)
                              && $stable(mem_dsp_sel) && $stable(mem_wide));

  // R10
  mem_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> !mem_req && resp_valid);

  // R9
  err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> resp_valid && (resp_rdata == 32'hFFFF_FFFF)
                 && !reg_strobe && !mem_req);

endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import win_pkg::*;
#(
  parameter int REG_WIN_LG   = 12,
  parameter int MEM_WIN_LG   = 16,
  parameter int LOCAL_REG_LG = 8,
  localparam int WORD_W      = MEM_WIN_LG - 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mem_space_en,
  input  logic [31:0]           base_regs,
  input  logic [31:0]           base_w24,
  input  logic [31:0]           base_w16,
  input  logic                  req_valid,
  input  logic [31:0]           req_addr,
  input  logic [3:0]            req_be,
  input  logic                  req_write,
  input  logic [31:0]           req_wdata,
  output logic                  resp_valid,
  output logic                  resp_err,
  output logic [31:0]           resp_rdata,
  output logic                  reg_strobe,
  output logic [REG_WIN_LG-1:0] reg_addr,
  output logic [3:0]            reg_be,
  output logic                  reg_write,
  output logic [31:0]           reg_wdata,
  input  logic [31:0]           reg_rdata,
  output logic                  mem_req,
  output logic                  mem_dsp_sel,
  output logic                  mem_wide,
  output logic [WORD_W-1:0]     mem_word_off,
  output logic                  mem_write,
  output logic [23:0]           mem_wdata,
  input  logic                  mem_ack,
  input  logic [23:0]           mem_rdata
);

  acc_kind_e             dec_kind;
  logic [REG_WIN_LG-1:0] dec_reg_off;
  logic                  dec_dsp;
  logic                  dec_wide;
  logic [WORD_W-1:0]     dec_word;
  logic                  seq_busy;

  // Named decode events for the checks below.
  logic evt_accept, evt_reject;
  assign evt_accept = req_valid && !seq_busy && (dec_kind inside {K_REG, K_MEM});
  assign evt_reject = req_valid && !seq_busy && (dec_kind == K_ERR);

  win_classify #(
    .REG_WIN_LG  (REG_WIN_LG),
    .MEM_WIN_LG  (MEM_WIN_LG),
    .LOCAL_REG_LG(LOCAL_REG_LG)
  ) u_classify (
    .en       (mem_space_en),
    .base_regs(base_regs),
    .base_w24 (base_w24),
    .base_w16 (base_w16),
    .addr     (req_addr),
    .be       (req_be),
    .kind     (dec_kind),
    .reg_off  (dec_reg_off),
    .dsp_sel  (dec_dsp),
    .wide     (dec_wide),
    .word_off (dec_word)
  );

  win_sequencer #(
    .REG_WIN_LG(REG_WIN_LG),
    .WORD_W    (WORD_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .kind        (dec_kind),
    .reg_off     (dec_reg_off),
    .be          (req_be),
    .write       (req_write),
    .wdata       (req_wdata),
    .dsp_sel     (dec_dsp),
    .wide        (dec_wide),
    .word_off    (dec_word),
    .busy        (seq_busy),
    .resp_valid  (resp_valid),
    .resp_err    (resp_err),
    .resp_rdata  (resp_rdata),
    .reg_strobe  (reg_strobe),
    .reg_addr    (reg_addr),
    .reg_be      (reg_be),
    .reg_write   (reg_write),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .mem_req     (mem_req),
    .mem_dsp_sel (mem_dsp_sel),
    .mem_wide    (mem_wide),
    .mem_word_off(mem_word_off),
    .mem_write   (mem_write),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata)
  );

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_strobe || $rose(mem_req)) |-> $past(mem_space_en));

  // R6
  mem_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(req_be) == 4'hF);

  // R9
  reject_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> resp_err && !reg_strobe && !mem_req);

  // R1
  accept_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> $onehot({reg_strobe, mem_req}) && !resp_valid);

  // R5
  dsp_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_dsp_sel == $past(req_addr[MEM_WIN_LG-1]));

endmodule

// File: tb/mem_window_decoder_test.sv
module mem_window_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int REG_LG  = 12;
  localparam int MEM_LG  = 16;
  localparam int WW      = MEM_LG - 3;
  localparam logic [31:0] RB  = 32'h1000_0000;
  localparam logic [31:0] B24 = 32'h2000_0000;
  localparam logic [31:0] B16 = 32'h3000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_space_en = 1'b0;
  logic [31:0] base_regs = RB, base_w24 = B24, base_w16 = B16;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic reg_strobe, reg_write;
  logic [REG_LG-1:0] reg_addr;
  logic [3:0] reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic mem_req, mem_dsp_sel, mem_wide, mem_write;
  logic [WW-1:0] mem_word_off;
  logic [23:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [23:0] mem_rdata = '0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Register file model: read data tagged by offset.
  assign reg_rdata = 32'hC0DE_0000 | {20'h0, reg_addr};

  mem_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .mem_space_en(mem_space_en),
    .base_regs(base_regs), .base_w24(base_w24), .base_w16(base_w16),
    .req_valid(req_valid), .req_addr(req_addr), .req_be(req_be),
    .req_write(req_write), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .reg_strobe(reg_strobe), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_write(reg_write), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_dsp_sel(mem_dsp_sel), .mem_wide(mem_wide),
    .mem_word_off(mem_word_off), .mem_write(mem_write), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one request pulse; returns at the falling edge after it was taken.
  task automatic issue(input logic [31:0] a, input logic [3:0] be,
                       input logic wr, input logic [31:0] d);
    req_valid = 1'b1; req_addr = a; req_be = be; req_write = wr; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_silence(input string tag);
    for (int i = 0; i < 3; i++) begin
      chk({tag, " strobe"}, {31'h0, reg_strobe}, 32'h0);
      chk({tag, " mem_req"}, {31'h0, mem_req}, 32'h0);
      chk({tag, " resp"}, {31'h0, resp_valid}, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic expect_error(input string tag);
    chk({tag, " err"}, {30'h0, resp_valid, resp_err}, 32'h3);
    chk({tag, " ones"}, resp_rdata, 32'hFFFF_FFFF);
    chk({tag, " no access"}, {30'h0, reg_strobe, mem_req}, 32'h0);
    @(negedge clk);
    chk({tag, " err one cycle"}, {30'h0, resp_valid, resp_err}, 32'h0);
  endtask

  // Memory handshake, entered one cycle after the request.
  task automatic mem_cycle(input string tag, input logic dsp, input logic wide,
                           input logic [WW-1:0] word, input logic wr,
                           input logic [23:0] wd, input logic [23:0] rd,
                           input logic [31:0] exp_resp);
    chk({tag, " R5 req"}, {31'h0, mem_req}, 32'h1);
    chk({tag, " R5 dsp"}, {31'h0, mem_dsp_sel}, {31'h0, dsp});
    chk({tag, " R3/R4 wide"}, {31'h0, mem_wide}, {31'h0, wide});
    chk({tag, " R5 word"}, {19'h0, mem_word_off}, {19'h0, word});
    chk({tag, " dir"}, {31'h0, mem_write}, {31'h0, wr});
    if (wr) chk({tag, " R3/R4 wdata"}, {8'h0, mem_wdata}, {8'h0, wd});
    @(negedge clk);
    chk({tag, " R10 hold"}, {18'h0, mem_req, mem_word_off}, {18'h0, 1'b1, word});
    chk({tag, " R10 no early resp"}, {31'h0, resp_valid}, 32'h0);
    mem_ack = 1'b1; mem_rdata = rd;
    @(negedge clk);
    mem_ack = 1'b0;
    chk({tag, " R10 drop"}, {31'h0, mem_req}, 32'h0);
    chk({tag, " R10 resp"}, {30'h0, resp_valid, resp_err}, 32'h2);
    chk({tag, " rdata"}, resp_rdata, exp_resp);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R12 reset outputs", {28'h0, reg_strobe, mem_req, resp_valid, resp_err}, 32'h0);
  endtask

  task automatic t_reg_write;
    issue(RB + 32'h124, 4'hF, 1'b1, 32'hDEAD_BEEF);
    chk("R1 strobe", {31'h0, reg_strobe}, 32'h1);
    chk("R1 offset", {20'h0, reg_addr}, 32'h124);
    chk("R1 wdata", reg_wdata, 32'hDEAD_BEEF);
    chk("R1 dir", {31'h0, reg_write}, 32'h1);
    chk("R1 no resp yet", {31'h0, resp_valid}, 32'h0);
    @(negedge clk);
    chk("R1 strobe one cycle", {31'h0, reg_strobe}, 32'h0);
    chk("R1 write resp", {30'h0, resp_valid, resp_err}, 32'h2);
    chk("R1 write rdata zero", resp_rdata, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reg_read;
    issue(RB + 32'hFFC, 4'hF, 1'b0, 32'h0);
    chk("R1 read offset", {20'h0, reg_addr}, 32'hFFC);
    @(negedge clk);
    chk("R1 read resp", {30'h0, resp_valid, resp_err}, 32'h2);
    chk("R1 read data", resp_rdata, 32'hC0DE_0FFC);
    @(negedge clk);
  endtask

  task automatic t_reg_partial;
    issue(RB + 32'h0FC, 4'b0010, 1'b1, 32'h0000_AA00);
    chk("R2 local byte strobe", {31'h0, reg_strobe}, 32'h1);
    chk("R2 local byte be", {28'h0, reg_be}, 32'h2);
    @(negedge clk);
    @(negedge clk);
    issue(RB + 32'h100, 4'b0001, 1'b1, 32'h55);
    expect_error("R2 R9 far byte");
    @(negedge clk);
  endtask

  task automatic t_mem24;
    issue(B24 + 32'h40, 4'hF, 1'b1, 32'hFF12_3456);
    mem_cycle("R3 w24 lo write", 1'b0, 1'b1, WW'(16), 1'b1, 24'h123456, 24'h0, 32'h0);
    issue(B24 + 32'h8008, 4'hF, 1'b0, 32'h0);
    mem_cycle("R3 w24 hi read", 1'b1, 1'b1, WW'(2), 1'b0, 24'h0, 24'hA5B6C7, 32'h00A5_B6C7);
    issue(B24 + 32'h7FFC, 4'hF, 1'b0, 32'h0);
    mem_cycle("R5 w24 lo top", 1'b0, 1'b1, WW'(13'h1FFF), 1'b0, 24'h0, 24'h000001, 32'h1);
  endtask

  task automatic t_mem16;
    issue(B16 + 32'h8004, 4'hF, 1'b1, 32'h1234_ABCD);
    mem_cycle("R4 w16 hi write", 1'b1, 1'b0, WW'(1), 1'b1, 24'h00ABCD, 24'h0, 32'h0);
    issue(B16 + 32'h0010, 4'hF, 1'b0, 32'h0);
    mem_cycle("R4 w16 lo read", 1'b0, 1'b0, WW'(4), 1'b0, 24'h0, 24'h77BEEF, 32'h0000_BEEF);
  endtask

  task automatic t_mem_byte;
    issue(B24 + 32'h10, 4'b0011, 1'b1, 32'h1);
    expect_error("R6 R9 w24 partial");
    issue(B16 + 32'h10, 4'b1000, 1'b0, 32'h0);
    expect_error("R6 R9 w16 partial");
  endtask

  task automatic t_disabled;
    mem_space_en = 1'b0;
    issue(RB + 32'h8, 4'hF, 1'b1, 32'h1);
    expect_silence("R7 reg disabled");
    issue(B24 + 32'h8, 4'hF, 1'b0, 32'h0);
    expect_silence("R7 mem disabled");
    mem_space_en = 1'b1;
  endtask

  task automatic t_miss;
    issue(32'h5000_0000, 4'hF, 1'b1, 32'h1);
    expect_silence("R8 miss");
    issue(B24 + 32'h0001_0000, 4'hF, 1'b0, 32'h0);
    expect_silence("R8 just past w24");
  endtask

  task automatic t_priority;
    base_w16 = B24;
    issue(B24 + 32'h20, 4'hF, 1'b0, 32'h0);
    mem_cycle("R11 w24 over w16", 1'b0, 1'b1, WW'(8), 1'b0, 24'h0, 24'hFEDCBA, 32'h00FE_DCBA);
    base_regs = B24;
    issue(B24 + 32'h20, 4'hF, 1'b0, 32'h0);
    chk("R11 regs over mem strobe", {30'h0, reg_strobe, mem_req}, 32'h2);
    @(negedge clk);
    chk("R11 regs over mem data", resp_rdata, 32'hC0DE_0020);
    @(negedge clk);
    base_regs = RB;
    base_w16 = B16;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    mem_space_en = 1'b1;
    t_reg_write();
    t_reg_read();
    t_reg_partial();
    t_mem24();
    t_mem16();
    t_mem_byte();
    t_disabled();
    t_miss();
    t_priority();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule